// File: doc/BRIEF.md
# Ring-Chained FIFO Slice

This block is one storage slice of a deeper first-in first-out buffer. Several identical slices are linked into a closed ring, and all of them share one clock, the write data, the write enable and the read enable. A slice owns a small memory and two tokens. The write token is the right to accept the next word, and the read token is the right to deliver the next word. At any time, exactly one slice in the ring holds each token. A token moves forward one place after its holder has used the holder's final memory location. Because of this, successive words fill the slices one after another. They are read back in the same order in which they were written.

Each slice has a pass-out pulse for each token. That pulse drives the matching grant-in of the next slice in the ring, and the last slice feeds the first. One slice has its first-select pin tied low, and that slice holds both tokens when reset ends. The read side has no shared bus. Each slice presents its own registered word together with a valid strobe, and the surrounding logic selects the word from the slice whose strobe is high.

The ring-level status is built by ORing the per-slice flags:
- The empty and full flags are gated by token ownership, so their OR is exact.
- The nearness flags describe only the slice's own fill level, so their OR is an approximation.

Top module: `fifo_ring_slice`

## Requirements
- R1: While `rst` is high at a clock edge, the slice clears its fill count and its pointers, and it sets `rd_data` to zero and `rd_valid` low. It takes both tokens if `first_n` is 0 and neither token if `first_n` is 1.
- R2: A word is stored only when `wr_en` is high, the slice holds the write token, and its count is below DEPTH. Stored words go to locations 0, 1, … DEPTH-1 in turn.
- R3: A store into location DEPTH-1 drives `xo_wr` high in the same cycle, and the write token is released at that edge. A slice that sees `xi_wr` high at an edge owns the write token from that edge on, so the ring loses no write cycle. At most one slice owns the write token.
- R4: When `rd_en` is high, the slice holds the read token, and its count is nonzero, the oldest stored word appears on `rd_data` after that edge. `rd_valid` is high for exactly that one cycle.
- R5: A read of location DEPTH-1 drives `xo_rd` high in the same cycle, and the read token is released at that edge. `xi_rd` high at an edge grants the read token.
- R6: With no accepted read, `rd_data` keeps its last value. A read request to an empty slice, or to a slice without the read token, leaves `rd_data` unchanged and `rd_valid` low.
- R7: `full` is high exactly when the slice holds the write token and holds DEPTH words. A write request while `full` is high is dropped, and the stored words do not change.
- R8: `empty` is high exactly when the slice holds the read token and holds no words.
- R9: `almost_empty` is high when the count is at most AE_LVL. `almost_full` is high when the count is at least DEPTH-AF_LVL. Neither flag depends on the tokens.
- R10: An accepted write and an accepted read in the same slice on the same edge are both carried out, and the count stays the same.
- R11: In a ring of slices, the OR of the `full` flags and the OR of the `empty` flags give the exact ring state. Words leave the ring in the order they were written, over many trips of the tokens around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| first_n | input | 1 | 0 selects the slice that owns both tokens after reset |
| wr_en | input | 1 | Write request, shared across the ring |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request, shared across the ring |
| xi_wr | input | 1 | Write-token grant from the previous slice |
| xi_rd | input | 1 | Read-token grant from the previous slice |
| xo_wr | output | 1 | Write-token pass pulse to the next slice |
| xo_rd | output | 1 | Read-token pass pulse to the next slice |
| rd_data | output | WIDTH | Last word read from this slice |
| rd_valid | output | 1 | High for the cycle after this slice delivered a word |
| wr_tok | output | 1 | Slice holds the write token |
| rd_tok | output | 1 | Slice holds the read token |
| empty | output | 1 | Read-token holder with no words |
| full | output | 1 | Write-token holder with no room |
| almost_empty | output | 1 | Fill count at or below AE_LVL |
| almost_full | output | 1 | Fill count at or above DEPTH-AF_LVL |

## Verification
The two functions that can fall in the same cycle are a write and a read on one slice. A close variant is the write-token hand-off and the read-token hand-off happening on the same edge. Both cases are provoked by a ring of three four-word slices:
- Seeded random streams with both enables frequently high make the two pointers land together on a slice, and sometimes together on its last location.
- Directed cases add a request against a full ring while reading, and reads from an empty ring.

A bench model of token positions, per-slice counts and a word queue judges each edge. It checks the pass pulses before the edge, and it checks the strobes, data, tokens and flags after the edge.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_BOTH  = 2'd3
    } slice_op_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } slice_flags_t;

    function automatic slice_op_e op_from(input logic rd_fire, input logic wr_fire);
        return slice_op_e'({rd_fire, wr_fire});
    endfunction

endpackage

// File: rtl/ring_token.sv
module ring_token (
    input  logic clk,
    input  logic rst,
    input  logic is_first,
    input  logic grant_in,
    input  logic op_fire,
    input  logic at_last,
    output logic holds,
    output logic pass_out
);

    assign pass_out = op_fire & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            holds <= is_first;
        end else begin
            holds <= (holds & ~pass_out) | grant_in;
        end
    end

    // R3
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        grant_in |-> (!holds || pass_out));

endmodule

// File: rtl/slice_store.sv
module slice_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_fire,
    output logic [AW-1:0]    wr_ptr,
    output logic [AW-1:0]    rd_ptr,
    output logic             wr_last,
    output logic             rd_last,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];

    assign wr_last = (wr_ptr == LAST);
    assign rd_last = (rd_ptr == LAST);

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_fire) begin
            wr_ptr <= wr_last ? '0 : wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                rd_data <= mem[rd_ptr];
                rd_ptr  <= rd_last ? '0 : rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/slice_level.sv
module slice_level
    import fifo_ring_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CW     = 5,
    parameter int AE_LVL = 2,
    parameter int AF_LVL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  slice_op_e     op,
    input  logic          wr_tok,
    input  logic          rd_tok,
    output logic [CW-1:0] cnt,
    output slice_flags_t  flags
);

    localparam logic [CW-1:0] TOP     = CW'(DEPTH);
    localparam logic [CW-1:0] AE_MARK = CW'(AE_LVL);
    localparam logic [CW-1:0] AF_MARK = CW'(DEPTH - AF_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                OP_WRITE: cnt <= cnt + 1'b1;
                OP_READ:  cnt <= cnt - 1'b1;
                default:  cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        flags.empty        = rd_tok && (cnt == '0);
        flags.full         = wr_tok && (cnt == TOP);
        flags.almost_empty = (cnt <= AE_MARK);
        flags.almost_full  = (cnt >= AF_MARK);
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

endmodule

// File: rtl/fifo_ring_slice.sv
module fifo_ring_slice
    import fifo_ring_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 16,
    parameter int AE_LVL = 2,
    parameter int AF_LVL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr,
    output logic             xo_rd,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             wr_tok,
    output logic             rd_tok,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_last, rd_last;
    logic          wr_fire, rd_fire;
    slice_flags_t  flags;
    slice_op_e     op;

    assign wr_fire = wr_en & wr_tok & (cnt != CW'(DEPTH));
    assign rd_fire = rd_en & rd_tok & (cnt != '0);
    assign op      = op_from(rd_fire, wr_fire);

    ring_token u_wtok (
        .clk      (clk),
        .rst      (rst),
        .is_first (~first_n),
        .grant_in (xi_wr),
        .op_fire  (wr_fire),
        .at_last  (wr_last),
        .holds    (wr_tok),
        .pass_out (xo_wr)
    );

    ring_token u_rtok (
        .clk      (clk),
        .rst      (rst),
        .is_first (~first_n),
        .grant_in (xi_rd),
        .op_fire  (rd_fire),
        .at_last  (rd_last),
        .holds    (rd_tok),
        .pass_out (xo_rd)
    );

    slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_fire  (wr_fire),
        .wr_data  (wr_data),
        .rd_fire  (rd_fire),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    slice_level #(.DEPTH(DEPTH), .CW(CW), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_level (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_tok (wr_tok),
        .rd_tok (rd_tok),
        .cnt    (cnt),
        .flags  (flags)
    );

    assign empty        = flags.empty;
    assign full         = flags.full;
    assign almost_empty = flags.almost_empty;
    assign almost_full  = flags.almost_full;

    // R4
    rd_tok_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_tok));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> $stable(rd_data));

    // R6
    empty_block_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en) |=> !rd_valid);

    // R3
    wr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        xo_wr |=> (wr_ptr == '0));

    // R5
    rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        xo_rd |=> (rd_ptr == '0));

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> $stable(wr_ptr));

    // R10
    both_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && rd_fire) |=> $stable(cnt));

endmodule

// File: tb/fifo_ring_slice_tb_top.sv
module fifo_ring_slice_tb_top;

    localparam int W  = 18;
    localparam int D  = 4;
    localparam int N  = 3;
    localparam int AE = 1;
    localparam int AF = 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [N-1:0] xo_wr, xo_rd, rd_valid, wr_tok, rd_tok, empty, full, ae, af;
    logic [W-1:0] rd_data [N];

    for (genvar i = 0; i < N; i++) begin : g_slice
        fifo_ring_slice #(.WIDTH(W), .DEPTH(D), .AE_LVL(AE), .AF_LVL(AF)) dut_i (
            .clk          (clk),
            .rst          (rst),
            .first_n      (i != 0),
            .wr_en        (wr_en),
            .wr_data      (wr_data),
            .rd_en        (rd_en),
            .xi_wr        (xo_wr[(i + N - 1) % N]),
            .xi_rd        (xo_rd[(i + N - 1) % N]),
            .xo_wr        (xo_wr[i]),
            .xo_rd        (xo_rd[i]),
            .rd_data      (rd_data[i]),
            .rd_valid     (rd_valid[i]),
            .wr_tok       (wr_tok[i]),
            .rd_tok       (rd_tok[i]),
            .empty        (empty[i]),
            .full         (full[i]),
            .almost_empty (ae[i]),
            .almost_full  (af[i])
        );
    end

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int wt = 0, rt = 0, wpos = 0, rpos = 0;
    int cnt [N];
    logic [W-1:0] last [N];
    logic [W-1:0] q [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_state();
        for (int i = 0; i < N; i++) begin
            chk(wr_tok[i] == (wt == i), "R3 write token owner", wr_tok[i], wt == i);
            chk(rd_tok[i] == (rt == i), "R5 read token owner", rd_tok[i], rt == i);
            chk(full[i] == (wt == i && cnt[i] == D), "R7 full flag", full[i], wt == i && cnt[i] == D);
            chk(empty[i] == (rt == i && cnt[i] == 0), "R8 empty flag", empty[i], rt == i && cnt[i] == 0);
            chk(ae[i] == (cnt[i] <= AE), "R9 almost_empty", ae[i], cnt[i] <= AE);
            chk(af[i] == (cnt[i] >= D - AF), "R9 almost_full", af[i], cnt[i] >= D - AF);
        end
        chk(((|full) == (q.size() == N * D && cnt[wt] == D)), "R11 composite full", |full, q.size() == N * D);
        chk(((|empty) == (q.size() == 0)), "R11 composite empty", |empty, q.size() == 0);
    endtask

    task automatic step(input bit we, input bit re, input logic [W-1:0] d);
        bit wacc, racc;
        int rt_old;
        logic [W-1:0] expw;
        @(negedge clk);
        wr_en = we; rd_en = re; wr_data = d;
        wacc = we && cnt[wt] < D;
        racc = re && cnt[rt] > 0;
        #1;
        for (int i = 0; i < N; i++) begin
            chk(xo_wr[i] == (wacc && i == wt && wpos == D - 1), "R3 write pass pulse",
                xo_wr[i], wacc && i == wt && wpos == D - 1);
            chk(xo_rd[i] == (racc && i == rt && rpos == D - 1), "R5 read pass pulse",
                xo_rd[i], racc && i == rt && rpos == D - 1);
        end
        @(posedge clk);
        #1;
        rt_old = rt;
        expw = '0;
        if (racc) begin
            expw = q.pop_front();
            cnt[rt]--;
            if (rpos == D - 1) begin rpos = 0; rt = (rt + 1) % N; end
            else rpos++;
        end
        if (wacc) begin
            q.push_back(d);
            cnt[wt]++;
            if (wpos == D - 1) begin wpos = 0; wt = (wt + 1) % N; end
            else wpos++;
        end
        for (int i = 0; i < N; i++) begin
            if (racc && i == rt_old) begin
                chk(rd_valid[i] == 1'b1, "R4 read strobe", rd_valid[i], 1);
                chk(rd_data[i] == expw, "R2 R11 word order", rd_data[i], expw);
                last[i] = expw;
            end else begin
                chk(rd_valid[i] == 1'b0, "R6 no strobe without read", rd_valid[i], 0);
                chk(rd_data[i] == last[i], "R6 data held", rd_data[i], last[i]);
            end
        end
        check_state();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin cnt[i] = 0; last[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(wr_tok == 3'b001, "R1 write token after reset", wr_tok, 1);
        chk(rd_tok == 3'b001, "R1 read token after reset", rd_tok, 1);
        chk(empty == 3'b001, "R1 empty after reset", empty, 1);
        chk(rd_valid == 3'b000, "R1 strobe low after reset", rd_valid, 0);
        chk(rd_data[0] == '0, "R1 data zero after reset", rd_data[0], 0);
        // R2 R3: fill the whole ring, then R7 dropped request
        for (int k = 0; k < N * D; k++) step(1'b1, 1'b0, W'(k + 1));
        step(1'b1, 1'b0, W'(18'h3ABCD));
        // R10 read while a write is requested against a full ring
        step(1'b1, 1'b1, W'(18'h00777));
        // drain everything, then R6 reads from an empty ring
        for (int k = 0; k < N * D + 2; k++) step(1'b0, 1'b1, '0);
        // R10 write and read on one slice in the same cycle
        step(1'b1, 1'b0, W'(18'h00111));
        step(1'b1, 1'b1, W'(18'h00222));
        step(1'b1, 1'b1, W'(18'h00333));
        // random phases: write-heavy, balanced, read-heavy
        for (int k = 0; k < 900; k++) begin
            bit we, re;
            if (k < 300)      begin we = ($urandom % 4) != 0; re = ($urandom % 3) == 0; end
            else if (k < 600) begin we = ($urandom % 2) != 0; re = ($urandom % 2) != 0; end
            else              begin we = ($urandom % 3) == 0; re = ($urandom % 4) != 0; end
            step(we, re, W'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule